// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus (clock and data, open drain). It holds one 8-bit control register that a bus master can write and read. Both bus lines are brought into the system clock domain through a synchroniser. Bus events are found by edge detection on the system clock: start, stop, and the rising and falling edges of the bus clock. The data line is driven only through an output enable, which pulls the line low while it is asserted.

A write transaction has four parts: a start, a device byte with the direction bit clear, a register index byte, and one data byte. The slave acknowledges each of the three bytes. The data byte lands in the register only when the index equals the parameter `REG_ADDR`. A read has a start (usually a repeated start after a dummy write), a device byte with the direction bit set, and then the register value shifted out most significant bit first. The slave keeps repeating the value while the master acknowledges each byte. After a master not-acknowledge, the slave releases the line. When a read is closed by a stop, the slave raises a standby flag, which it clears at the next start.

Top module: `twi_ctrl_reg_slave`

## Requirements
- R1: Before the first start condition, the slave never drives the data line, even if whole bytes are clocked on the bus.
- R2: The device byte matches only when bits [7:1] equal 7'b1011000, sent MSB first. A match is acknowledged by the slave holding the data line low for the ninth clock. A mismatch gets no acknowledge, and the slave ignores all later bytes until the next start.
- R3: In a write (device byte bit 0 = 0), the slave acknowledges the index byte and the data byte. When the index equals `REG_ADDR`, `ctrl_o` takes the data byte.
- R4: A write whose index differs from `REG_ADDR` is still acknowledged, but `ctrl_o` keeps its value.
- R5: In a read (device byte bit 0 = 1), after its acknowledge the slave sends the `ctrl_o` value MSB first. It changes each bit while the bus clock is low.
- R6: When the master acknowledges a read byte (data low on the ninth clock), the value is sent again. After a master not-acknowledge, the slave keeps the line released until the next start or stop.
- R7: A stop that ends a read sets `standby_o` to 1, and the next start clears it. A stop that ends a write leaves `standby_o` at 0.
- R8: `sda_oe_o` changes only while the synchronised bus clock is low, or right after a start or stop.
- R9: A stop in the middle of a data byte ends the transfer, and the register keeps its old value.
- R10: Bytes after the single data byte of a write get no acknowledge and do not change `ctrl_o`.
- R11: After reset, `ctrl_o` equals `RST_VAL`, and `sda_oe_o` and `standby_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| ctrl_o | output | 8 | Control register value |
| standby_o | output | 1 | Set by a stop that ends a read, cleared by the next start |

## Verification
A wrong protocol state shows at the ports within one bus bit. If the slave is in the wrong state, an acknowledge appears or goes missing on the ninth clock of the byte being sent. It can also show as a data line that stays low after a not-acknowledge, or a read bit that arrives in the wrong position. A corrupted register or a write that should not have happened shows on `ctrl_o` as soon as the data acknowledge starts. A wrong record of the transfer direction shows on `standby_o` within a few system cycles after the stop.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edge with clock high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter logic [3:0]        DEV_ID   = 4'b1011,
  parameter logic [BYTE_W-1:0] REG_ADDR = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              oe_o,
  output logic              standby_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  twi_state_e        state_q, next_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              oe_q, rw_q, hit_q, standby_q;
  logic              byte_done;

  assign byte_done = scl_fall_i && (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      next_q    <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      hit_q     <= 1'b0;
      standby_q <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_DEV;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      standby_q <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
      standby_q <= rw_q;
    end else begin
      unique case (state_q)
        ST_DEV, ST_REG, ST_DATA: begin
          if (scl_rise_i && cnt_q != CNT_FULL) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (rx_q[7:1] == {DEV_ID, 3'b000}) begin
                oe_q    <= 1'b1;
                rw_q    <= rx_q[0];
                next_q  <= rx_q[0] ? ST_TX : ST_REG;
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_REG) begin
              hit_q   <= (rx_q == REG_ADDR);
              oe_q    <= 1'b1;
              next_q  <= ST_DATA;
              state_q <= ST_ACK;
            end else begin
              oe_q    <= 1'b1;
              next_q  <= ST_HOLD;
              state_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (next_q == ST_TX) begin
              oe_q  <= ~reg_i[BYTE_W-1];
              tx_q  <= {reg_i[BYTE_W-2:0], 1'b0};
              cnt_q <= CNT_W'(1);
            end else begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
            end
            state_q <= next_q;
          end
        end
        ST_TX: begin
          if (byte_done) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_MACK;
          end else if (scl_fall_i) begin
            oe_q  <= ~tx_q[BYTE_W-1];
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            // master ack low: resend on next clock low
            if (sda_i) begin
              state_q <= ST_HOLD;
            end else begin
              next_q  <= ST_TX;
              state_q <= ST_ACK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = !start_i && !stop_i && (state_q == ST_DATA) && byte_done && hit_q;
  assign wr_data_o = rx_q;
  assign oe_o      = oe_q;
  assign standby_o = standby_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_HOLD || state_q == ST_MACK) |-> !oe_q) else $error("oe in idle"); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe_q)) else $error("oe moved, scl high"); // R8
  AST_BIT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL) else $error("bit count overflow"); // R2
  AST_STANDBY_BY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_q) |-> $past(stop_i)) else $error("standby without stop"); // R7
endmodule

// File: rtl/twi_ctrl_reg_slave.sv
module twi_ctrl_reg_slave
  import twi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REG_ADDR    = 8'h00,
  parameter logic [BYTE_W-1:0] RST_VAL     = 8'hA5,
  parameter logic [3:0]        DEV_ID      = 4'b1011,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              standby_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en;
  logic [BYTE_W-1:0] wr_data, ctrl_q;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  twi_slave_fsm #(.DEV_ID(DEV_ID), .REG_ADDR(REG_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .reg_i      (ctrl_q),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .oe_o       (sda_oe_o),
    .standby_o  (standby_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= RST_VAL;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> $rose(sda_oe_o)) else $error("register moved outside data ack"); // R3
endmodule

// File: tb/twi_ctrl_reg_slave_bench.sv
module twi_ctrl_reg_slave_bench;
  localparam logic [7:0] REG_ADDR = 8'h00;
  localparam logic [7:0] RST_VAL  = 8'hA5;
  localparam int         Q        = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, standby;
  logic [7:0] ctrl;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  logic [7:0] exp_ctrl;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  twi_ctrl_reg_slave #(.REG_ADDR(REG_ADDR), .RST_VAL(RST_VAL)) u_twi_ctrl_reg_slave (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .ctrl_o    (ctrl),
    .standby_o (standby)
  );

  function automatic logic dev_match(logic [7:0] b);
    return b[7:1] == 7'b1011000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, r);
      d = {d[6:0], r};
    end
    bit_io(~mack, r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d, a, ra, wd;
    void'($urandom(32'd1234));
    exp_ctrl = RST_VAL;
    repeat (5) @(negedge clk);
    chk("R11 ctrl", ctrl, RST_VAL);
    chk("R11 oe", sda_oe, 0);
    chk("R11 standby", standby, 0);
    rst_n = 1'b1;
    wq();

    // R1: bytes without any start
    scl_m = 1'b0; wq();
    send_byte(8'hB0, ack);
    chk("R1 no ack before start", ack, 0);
    send_byte(8'h00, ack);
    chk("R1 still silent", ack, 0);

    // R3 write, R10 extra byte
    bus_start();
    send_byte(8'hB0, ack); chk("R2 dev ack", ack, 1);
    send_byte(REG_ADDR, ack); chk("R3 index ack", ack, 1);
    send_byte(8'h3C, ack); chk("R3 data ack", ack, 1);
    exp_ctrl = 8'h3C;
    chk("R3 ctrl", ctrl, exp_ctrl);
    send_byte(8'h99, ack); chk("R10 extra no ack", ack, 0);
    chk("R10 ctrl kept", ctrl, exp_ctrl);
    bus_stop();
    chk("R7 standby after write", standby, 0);

    // R4 other index
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h77, ack); chk("R4 index ack", ack, 1);
    send_byte(8'h11, ack); chk("R4 data ack", ack, 1);
    bus_stop();
    chk("R4 ctrl kept", ctrl, exp_ctrl);

    // R5/R6 read with repeated start
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(REG_ADDR, ack);
    bus_start();
    send_byte(8'hB1, ack); chk("R5 read dev ack", ack, 1);
    recv_byte(1'b1, d); chk("R5 read data", d, exp_ctrl);
    recv_byte(1'b1, d); chk("R6 repeat after ack", d, exp_ctrl);
    recv_byte(1'b0, d); chk("R6 last byte", d, exp_ctrl);
    recv_byte(1'b0, d); chk("R6 released after nack", d, 8'hFF);
    bus_stop();
    chk("R7 standby after read", standby, 1);
    bus_start();
    chk("R7 standby cleared by start", standby, 0);
    send_byte(8'hB2, ack); chk("R2 bit1 set no ack", ack, 0);
    send_byte(8'hB0, ack); chk("R2 ignored until start", ack, 0);
    bus_stop();

    bus_start();
    send_byte(8'hB4, ack); chk("R2 bit2 set no ack", ack, 0);
    bus_stop();

    // R9 abort mid data
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(REG_ADDR, ack);
    for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
    bus_stop();
    chk("R9 abort keeps ctrl", ctrl, exp_ctrl);
    chk("R9 abort oe released", sda_oe, 0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic op;
      op = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : {7'b1011000, op};
      bus_start();
      send_byte(a, ack);
      chk("R2 random dev", ack, dev_match(a));
      if (!dev_match(a)) begin
        send_byte(8'($urandom()), ack);
        chk("R2 random ignored", ack, 0);
        bus_stop();
        chk("R7 random standby", standby, 0);
      end else if (!a[0]) begin
        ra = ($urandom_range(0, 1) == 1) ? REG_ADDR : 8'($urandom());
        wd = 8'($urandom());
        send_byte(ra, ack); chk("R3 random index ack", ack, 1);
        send_byte(wd, ack); chk("R3 random data ack", ack, 1);
        if (ra == REG_ADDR) exp_ctrl = wd;
        bus_stop();
        chk("R4 random ctrl", ctrl, exp_ctrl);
        chk("R7 random standby", standby, 0);
      end else begin
        recv_byte(1'b0, d); chk("R5 random read", d, exp_ctrl);
        bus_stop();
        chk("R7 random standby", standby, 1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule